// File: doc/BRIEF.md
# UART Transmit Flow Gate

This block sits between the holding FIFO of a UART transmitter and its shift register. It decides, one character at a time, whether the next character may be handed to the shift register. The decision depends on an active-low modem handshake input from the far end. A control bit picks which of two modem inputs (clear-to-send or data-set-ready) is watched. A separate enable bit turns automatic gating on.

The gate only ever acts at a character boundary. A character that the shift register has already accepted always runs to the end of its stop bit. Only the hand-off of the next character is held back. The block also watches the selected input for changes in either direction and raises a maskable interrupt, with a status flag that is cleared by reading it.

The serial timing, the baud generator and the FIFO storage are outside the block. The FIFO is seen as a valid/pop pair, and the shift register is seen as a busy level and a load strobe.

Top module: `uart_tx_flow_gate`

## Requirements
- R1: After reset every control bit is clear, `irq` is 0 and `isr_data` is 0. With the gate off, `tx_load` equals `fifo_valid && !tx_busy`.
- R2: While automatic gating is disabled (bit 7 of the feature register, `wr_addr` = 1, clear), the level of the modem inputs has no effect on `tx_load`.
- R3: With gating enabled, once the selected input has been high for two clock edges, `tx_load` and `fifo_pop` stay 0 even when the FIFO holds data and the shifter is idle.
- R4: `tx_load` is never asserted while `tx_busy` is high, so a character in progress always finishes. `fifo_pop` always equals `tx_load`, and `tx_char` carries `fifo_data`.
- R5: Loads resume on the second clock edge after the selected input returns low.
- R6: Bit 2 of the modem control register (`wr_addr` = 0) selects the input: 0 selects `cts_n` and 1 selects `dsr_n`. The input that is not selected is ignored.
- R7: Bit 7 of the interrupt enable register (`wr_addr` = 2) can be written only while bit 4 of the feature register is set. A write while that bit is clear leaves the enable unchanged.
- R8: With the interrupt enabled, each rising or falling transition of the selected input sets bit 5 of `isr_data` and asserts `irq` on the third clock edge after the pin changes.
- R9: A read strobe `isr_rd` clears the bit-5 flag on the next edge. If a new transition is detected in the same cycle as the read, the flag stays set.
- R10: `irq` is the flag masked by the interrupt enable. Clearing the enable drops `irq` but leaves the flag readable. Transitions seen while the enable is clear do not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| wr_en | input | 1 | Control register write strobe |
| wr_addr | input | 2 | 0 modem control, 1 feature, 2 interrupt enable |
| wr_data | input | 8 | Write data |
| isr_rd | input | 1 | Interrupt status read strobe (clears flag) |
| isr_data | output | 8 | Interrupt status, bit 5 is the flow-change flag |
| irq | output | 1 | Interrupt request |
| fifo_valid | input | 1 | Holding FIFO has a character |
| fifo_data | input | 8 | Character at the FIFO head |
| fifo_pop | output | 1 | Remove the head character |
| tx_busy | input | 1 | Shift register is sending a character |
| tx_load | output | 1 | Load the shift register with `tx_char` |
| tx_char | output | 8 | Character handed to the shift register |

## Verification
Two functions can land in the same cycle: the status read that clears the flag, and a newly detected transition that sets it. The bench provokes this by setting `isr_rd` for exactly the cycle in which a pin change reaches the end of the synchronizer. It expects the flag to survive, because setting takes priority. The bench also overlaps a busy shifter with a deasserting input. This confirms that no load happens during the busy period or after it while the input stays high.

// File: rtl/uart_flow_pkg.sv
package uart_flow_pkg;

    typedef enum logic [1:0] {
        REG_MODEM   = 2'd0,
        REG_FEATURE = 2'd1,
        REG_IRQEN   = 2'd2,
        REG_SPARE   = 2'd3
    } reg_sel_e;

    localparam int MODE_BIT   = 2;
    localparam int AUTO_BIT   = 7;
    localparam int UNLOCK_BIT = 4;
    localparam int IRQEN_BIT  = 7;
    localparam int FLAG_BIT   = 5;

    typedef struct packed {
        logic use_dsr;
        logic auto_en;
        logic unlock;
        logic irq_en;
    } flow_ctrl_t;

    function automatic logic pick_input(input logic use_dsr,
                                        input logic cts_s,
                                        input logic dsr_s);
        return use_dsr ? dsr_s : cts_s;
    endfunction

endpackage

// File: rtl/flow_sync.sv
module flow_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RST_VAL;
                else     chain <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RST_VAL}};
                else     chain <= {chain[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/flow_regs.sv
module flow_regs
    import uart_flow_pkg::*;
#(
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    output flow_ctrl_t       ctrl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_MODEM: ctrl.use_dsr <= wr_data[MODE_BIT];
                REG_FEATURE: begin
                    ctrl.auto_en <= wr_data[AUTO_BIT];
                    ctrl.unlock  <= wr_data[UNLOCK_BIT];
                end
                REG_IRQEN: begin
                    if (ctrl.unlock) ctrl.irq_en <= wr_data[IRQEN_BIT];
                end
                default: ;
            endcase
        end
    end

    logic unused_bits;
    assign unused_bits = ^wr_data;
endmodule

// File: rtl/flow_irq.sv
module flow_irq (
    input  logic clk,
    input  logic rst,
    input  logic level,
    input  logic irq_en,
    input  logic rd_stb,
    output logic edge_pulse,
    output logic flag
);
    logic level_prev;

    assign edge_pulse = level ^ level_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            level_prev <= 1'b1;
            flag       <= 1'b0;
        end else begin
            level_prev <= level;
            if (edge_pulse && irq_en) flag <= 1'b1;
            else if (rd_stb)          flag <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_tx_flow_gate.sv
module uart_tx_flow_gate
    import uart_flow_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int REG_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              isr_rd,
    output logic [REG_W-1:0]  isr_data,
    output logic              irq,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_pop,
    input  logic              tx_busy,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_char
);
    localparam int N_PINS = 2;

    flow_ctrl_t        ctrl;
    logic [N_PINS-1:0] pin_raw;
    logic [N_PINS-1:0] pin_sync;
    logic              sel_level;
    logic              edge_pulse;
    logic              flag;
    logic              hold_off;

    assign pin_raw = {dsr_n, cts_n};

    generate
        for (genvar g = 0; g < N_PINS; g++) begin : g_sync
            flow_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
                .clk  (clk),
                .rst  (rst),
                .din  (pin_raw[g]),
                .dout (pin_sync[g])
            );
        end
    endgenerate

    flow_regs #(.REG_W(REG_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    assign sel_level = pick_input(ctrl.use_dsr, pin_sync[0], pin_sync[1]);

    flow_irq u_irq (
        .clk        (clk),
        .rst        (rst),
        .level      (sel_level),
        .irq_en     (ctrl.irq_en),
        .rd_stb     (isr_rd),
        .edge_pulse (edge_pulse),
        .flag       (flag)
    );

    assign hold_off = ctrl.auto_en & sel_level;
    assign tx_load  = fifo_valid & ~tx_busy & ~hold_off;
    assign fifo_pop = tx_load;
    assign tx_char  = fifo_data;
    assign irq      = flag & ctrl.irq_en;

    always_comb begin
        isr_data           = '0;
        isr_data[FLAG_BIT] = flag;
    end
endmodule

// File: rtl/flow_gate_checker.sv
module flow_gate_checker (
    input logic       clk,
    input logic       rst,
    input logic       tx_busy,
    input logic       tx_load,
    input logic       fifo_valid,
    input logic       isr_rd,
    input logic       flag_bit,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       edge_pulse,
    input logic       irq_en,
    input logic       unlock,
    input logic       auto_en,
    input logic       sel_level
);
    AST_NO_LOAD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> (!tx_busy && fifo_valid)); // R4

    AST_GATED_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
        (auto_en && sel_level) |-> !tx_load); // R3

    AST_LOCKED_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd2 && !unlock) |=> $stable(irq_en)); // R7

    AST_EDGE_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (edge_pulse && irq_en) |=> flag_bit); // R8

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (isr_rd && !(edge_pulse && irq_en)) |=> !flag_bit); // R9
endmodule

bind uart_tx_flow_gate flow_gate_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .tx_busy    (tx_busy),
    .tx_load    (tx_load),
    .fifo_valid (fifo_valid),
    .isr_rd     (isr_rd),
    .flag_bit   (isr_data[5]),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .edge_pulse (edge_pulse),
    .irq_en     (ctrl.irq_en),
    .unlock     (ctrl.unlock),
    .auto_en    (ctrl.auto_en),
    .sel_level  (sel_level)
);

// File: tb/uart_tx_flow_gate_bench.sv
`timescale 1ns/1ps
module uart_tx_flow_gate_bench;
    localparam int STG = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cts_n = 1'b0, dsr_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic       isr_rd = 1'b0;
    logic [7:0] isr_data;
    logic       irq;
    logic       fifo_valid = 1'b1;
    logic [7:0] fifo_data = 8'h5A;
    logic       fifo_pop;
    logic       tx_busy = 1'b0;
    logic       tx_load;
    logic [7:0] tx_char;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    always #2 clk = ~clk;

    uart_tx_flow_gate u_uart_tx_flow_gate (
        .clk(clk), .rst(rst), .cts_n(cts_n), .dsr_n(dsr_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .isr_rd(isr_rd), .isr_data(isr_data), .irq(irq),
        .fifo_valid(fifo_valid), .fifo_data(fifo_data), .fifo_pop(fifo_pop),
        .tx_busy(tx_busy), .tx_load(tx_load), .tx_char(tx_char)
    );

    // behavioural reference
    bit m_dsr_sel, m_auto, m_unlock, m_ier, m_flag, m_prev;
    bit q_cts[$];
    bit q_dsr[$];

    function automatic bit m_level();
        bit c, d;
        c = q_cts[q_cts.size() - STG];
        d = q_dsr[q_dsr.size() - STG];
        return m_dsr_sel ? d : c;
    endfunction

    initial begin
        for (int i = 0; i < STG; i++) begin
            q_cts.push_back(1'b1);
            q_dsr.push_back(1'b1);
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            m_dsr_sel = 0; m_auto = 0; m_unlock = 0; m_ier = 0;
            m_flag = 0; m_prev = 1;
            q_cts.push_back(1'b1);
            q_dsr.push_back(1'b1);
        end else begin
            bit lv;
            lv = m_level();
            if (m_ier && (lv != m_prev)) m_flag = 1;
            else if (isr_rd)             m_flag = 0;
            m_prev = lv;
            if (wr_en) begin
                if (wr_addr == 2'd0) m_dsr_sel = wr_data[2];
                if (wr_addr == 2'd1) begin m_auto = wr_data[7]; m_unlock = wr_data[4]; end
                if (wr_addr == 2'd2 && m_unlock) m_ier = wr_data[7];
            end
            q_cts.push_back(cts_n);
            q_dsr.push_back(dsr_n);
        end
        while (q_cts.size() > STG) void'(q_cts.pop_front());
        while (q_dsr.size() > STG) void'(q_dsr.pop_front());
    end

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, got, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            bit exp_load;
            exp_load = fifo_valid && !tx_busy && !(m_auto && m_level());
            check("R3 tx_load vs model", tx_load, exp_load);
            check("R4 fifo_pop vs model", fifo_pop, exp_load);
            check("R4 tx_char", tx_char, fifo_data);
            check("R10 irq vs model", irq, m_flag && m_ier);
            check("R8 isr_data vs model", isr_data, {2'b00, m_flag, 5'b0});
        end
    end

    task automatic tick(int n = 1);
        repeat (n) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic write_reg(logic [1:0] a, logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0; wr_addr = 2'd3;
    endtask

    task automatic read_isr();
        isr_rd = 1'b1;
        tick();
        isr_rd = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R1 watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        check("R1 reset load", tx_load, 1);
        check("R1 reset irq", irq, 0);
        check("R1 reset status", isr_data, 8'h00);

        cts_n = 1'b1;
        tick(3);
        check("R2 disabled gate ignores cts", tx_load, 1);

        write_reg(2'd1, 8'h80);
        check("R3 gated load", tx_load, 0);
        check("R3 gated pop", fifo_pop, 0);

        cts_n = 1'b0;
        tick();
        check("R5 still held after one edge", tx_load, 0);
        tick();
        check("R5 resumed", tx_load, 1);

        tx_busy = 1'b1;
        tick();
        check("R4 busy blocks load", tx_load, 0);
        cts_n = 1'b1;
        tick(2);
        tx_busy = 1'b0;
        #0.1;
        check("R3 idle shifter stays gated", tx_load, 0);
        cts_n = 1'b0;
        tick(2);
        check("R5 resume after idle hold", tx_load, 1);

        write_reg(2'd0, 8'h04);
        dsr_n = 1'b1;
        tick(2);
        check("R6 dsr selected gates", tx_load, 0);
        cts_n = 1'b1; dsr_n = 1'b0;
        tick(2);
        check("R6 cts ignored when dsr selected", tx_load, 1);
        cts_n = 1'b0;

        write_reg(2'd2, 8'h80);
        dsr_n = 1'b1;
        tick(4);
        check("R7 locked enable irq", irq, 0);
        check("R7 locked enable status", isr_data, 8'h00);
        dsr_n = 1'b0;
        tick(4);

        write_reg(2'd1, 8'h90);
        write_reg(2'd2, 8'h80);
        tick(2);
        dsr_n = 1'b1;
        tick(2);
        check("R8 not yet flagged", irq, 0);
        tick();
        check("R8 rise flagged irq", irq, 1);
        check("R8 rise flagged status", isr_data, 8'h20);

        read_isr();
        check("R9 read clears irq", irq, 0);
        check("R9 read clears status", isr_data, 8'h00);

        dsr_n = 1'b0;
        tick(3);
        check("R8 fall flagged", irq, 1);

        dsr_n = 1'b1;
        tick(2);
        isr_rd = 1'b1;
        tick();
        isr_rd = 1'b0;
        check("R9 set beats read", isr_data, 8'h20);
        read_isr();
        check("R9 cleared afterwards", isr_data, 8'h00);

        dsr_n = 1'b0;
        tick(3);
        write_reg(2'd2, 8'h00);
        check("R10 masked irq", irq, 0);
        check("R10 flag still visible", isr_data, 8'h20);
        read_isr();
        dsr_n = 1'b1;
        tick(4);
        check("R10 no flag while disabled", isr_data, 8'h00);

        write_reg(2'd1, 8'h80);
        write_reg(2'd2, 8'h80);
        dsr_n = 1'b0;
        tick(4);
        check("R7 relocked write ignored", isr_data, 8'h00);

        for (int i = 0; i < 600; i++) begin
            cts_n      = ($urandom % 5) == 0 ? ~cts_n : cts_n;
            dsr_n      = ($urandom % 5) == 0 ? ~dsr_n : dsr_n;
            fifo_valid = $urandom % 2;
            fifo_data  = 8'($urandom);
            tx_busy    = ($urandom % 3) == 0;
            isr_rd     = ($urandom % 4) == 0;
            if (($urandom % 6) == 0) begin
                wr_en   = 1'b1;
                wr_addr = 2'($urandom % 3);
                wr_data = 8'($urandom);
            end else begin
                wr_en = 1'b0;
            end
            tick();
        end
        wr_en = 1'b0; isr_rd = 1'b0;
        tick(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule